// File: doc/BRIEF.md
# Open-Loop Startup Frequency Ramp Sequencer

This block runs the open-loop start of a sensorless three-phase fan motor. On the first clock after reset is released it captures a 4-bit startup setting code and a one-bit voltage-select input. From these it derives three values that stay fixed until the next reset: an acceleration, a starting drive amplitude and a frequency ceiling. When a start request is present it ramps an electrical-frequency command upward. The command grows by a fixed step on every internal tick of `TICK_CYCLES` clocks, and one tick stands for 100 ms.

The ramp ends in one of two ways. If the frequency saturates at its ceiling, or if the closed-loop controller reports lock-in, the block hands over and holds the frequency at its last value. While the motor is driven, the block watches a rotation-pulse input. If no rising pulse edge arrives for `LOCK_TICKS` ticks, it treats the rotor as stalled. It then removes drive for `OFF_TICKS` ticks and restarts the ramp from zero without outside help.

Top module: `startup_ramp_seq`

## Requirements
- R1: While reset is held, `freq_o` and `amp_o` are 0 and `drive_o`, `open_loop_o` and `off_o` are low.
- R2: `code_i` and `vsel_i` are sampled only on the first clock edge after reset is released. Later changes to them change neither `amp_o` nor the ramp step until the next reset.
- R3: `freq_o` is in units of 0.01 Hz. While `open_loop_o` is high, it rises once per tick of `TICK_CYCLES` clocks by the latched acceleration. For codes 0, 1, 2, 3, 4, 5, 6 and 7 the acceleration is 31, 51, 70, 90, 109, 148, 188 and 266 (in 0.1 Hz/s). Codes 8 to 15 use 266.
- R4: `amp_o` gives the starting amplitude in volts. For codes 0 to 7 it is 6 when `vsel_i` was 1 and 3 when it was 0. For codes 8 to 15 it is 2 when `vsel_i` was 1 and 1 when it was 0.
- R5: A step that would pass the ceiling sets `freq_o` to the ceiling instead. The ceiling is 50000 for codes 0 to 7 and 100000 for codes 8 to 15. On that same edge `open_loop_o` falls while `drive_o` stays high.
- R6: When `lock_in_i` is high during the ramp, the next edge drops `open_loop_o`, keeps `drive_o` high and leaves `freq_o` unchanged.
- R7: A high `start_i` while idle starts the ramp on the next edge with `freq_o` = 0 and both `drive_o` and `open_loop_o` high. A low `start_i` in any state returns the block to idle, with `freq_o` = 0 and all three flags low, on the next edge.
- R8: While `drive_o` is high, a span of `LOCK_TICKS` ticks without a rising edge on `rot_pulse_i` raises `off_o`, clears `drive_o` and `open_loop_o`, and sets `freq_o` to 0. While idle, no stall is ever declared.
- R9: `off_o` stays high for exactly `OFF_TICKS`×`TICK_CYCLES` clocks. The ramp then restarts from 0 on its own, and its steps are the same as after a fresh start.
- R10: After hand-over, `freq_o` holds its value for as long as drive continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| code_i | input | 4 | Startup setting code, captured once after reset |
| vsel_i | input | 1 | Starting-voltage select, captured with the code |
| start_i | input | 1 | Start request (level) |
| lock_in_i | input | 1 | Closed loop has locked onto the rotor |
| rot_pulse_i | input | 1 | Rotation pulse, may be asynchronous |
| freq_o | output | FREQ_W (17) | Electrical-frequency command, 0.01 Hz units |
| amp_o | output | AMP_W (4) | Starting drive amplitude, volts |
| drive_o | output | 1 | Motor drive enabled |
| open_loop_o | output | 1 | Open-loop ramp in progress |
| off_o | output | 1 | Stall off period in progress |

## Verification
The bench builds the block with `TICK_CYCLES`=8, `LOCK_TICKS`=4, `OFF_TICKS`=3 and a two-stage pulse synchronizer. These values make a 100 ms tick eight clocks long. As a result, a full ramp to the 1000 Hz ceiling takes 376 steps and about 3000 cycles. A stall, its off period and the automatic restart each fit in a few dozen cycles. This makes it possible to walk every step of both ceilings, measure the tick spacing, the stall latency and the exact off-time length, and sweep all eight slow codes plus one fast alias.

// File: rtl/startup_ramp_pkg.sv
package startup_ramp_pkg;

   localparam int unsigned SET_CODE_W     = 4;
   localparam int unsigned SLOW_CEIL      = 50000;   // 500 Hz in 0.01 Hz units
   localparam int unsigned FAST_CEIL      = 100000;  // 1000 Hz in 0.01 Hz units
   localparam int unsigned ACC_MIN_W      = 9;
   localparam int unsigned FREQ_MIN_W     = 17;
   localparam int unsigned AMP_MIN_W      = 3;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RAMP = 2'd1,
      SEQ_RUN  = 2'd2,
      SEQ_OFF  = 2'd3
   } seq_state_e;

   // codes above 7 all select the fast, low-voltage set
   function automatic logic is_fast_set(input logic [SET_CODE_W-1:0] code);
      return code > 4'd7;
   endfunction

   // acceleration in 0.1 Hz/s == increment in 0.01 Hz per 100 ms tick
   function automatic int unsigned accel_of(input logic [SET_CODE_W-1:0] code);
      int unsigned a;
      case (code)
         4'd0:    a = 31;
         4'd1:    a = 51;
         4'd2:    a = 70;
         4'd3:    a = 90;
         4'd4:    a = 109;
         4'd5:    a = 148;
         4'd6:    a = 188;
         default: a = 266;
      endcase
      return a;
   endfunction

   function automatic int unsigned ceiling_of(input logic [SET_CODE_W-1:0] code);
      return is_fast_set(code) ? FAST_CEIL : SLOW_CEIL;
   endfunction

   function automatic int unsigned amp_of(input logic [SET_CODE_W-1:0] code,
                                          input logic                  sel);
      int unsigned v;
      if (is_fast_set(code)) v = sel ? 2 : 1;
      else                   v = sel ? 6 : 3;
      return v;
   endfunction

endpackage

// File: rtl/startup_cfg_latch.sv
module startup_cfg_latch
   import startup_ramp_pkg::*;
#(
   parameter int unsigned ACC_W  = 9,
   parameter int unsigned FREQ_W = 17,
   parameter int unsigned AMP_W  = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [SET_CODE_W-1:0] code_i,
   input  logic                  vsel_i,
   output logic                  valid_o,
   output logic [ACC_W-1:0]      accel_o,
   output logic [FREQ_W-1:0]     ceil_o,
   output logic [AMP_W-1:0]      amp_o
);

   if (ACC_W < ACC_MIN_W) begin : g_bad_acc
      $error("ACC_W too narrow for the acceleration table");
   end
   if (FREQ_W < FREQ_MIN_W) begin : g_bad_freq
      $error("FREQ_W too narrow for the fast ceiling");
   end
   if (AMP_W < AMP_MIN_W) begin : g_bad_amp
      $error("AMP_W too narrow for the amplitude table");
   end

   logic                  valid_q;
   logic [SET_CODE_W-1:0] code_q;
   logic                  vsel_q;

   // capture once, on the first edge out of reset (R2)
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         code_q  <= '0;
         vsel_q  <= 1'b0;
      end else if (!valid_q) begin
         valid_q <= 1'b1;
         code_q  <= code_i;
         vsel_q  <= vsel_i;
      end
   end

   always_comb begin
      valid_o = valid_q;
      accel_o = '0;
      ceil_o  = '0;
      amp_o   = '0;
      if (valid_q) begin
         accel_o = ACC_W'(accel_of(code_q));
         ceil_o  = FREQ_W'(ceiling_of(code_q));
         amp_o   = AMP_W'(amp_of(code_q, vsel_q));
      end
   end

   // R2: once captured, the derived settings never move
   p_cfg_frozen_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> (valid_o && $stable(accel_o) && $stable(ceil_o) && $stable(amp_o)));

endmodule

// File: rtl/startup_tick_gen.sv
module startup_tick_gen #(
   parameter int unsigned TICK_CYCLES = 2_500_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   localparam int unsigned CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

   if (TICK_CYCLES == 0) begin : g_bad_tick
      $error("TICK_CYCLES must be at least 1");
   end

   if (TICK_CYCLES == 1) begin : g_every_clk
      assign tick_o = 1'b1;
   end else begin : g_divider
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni)            cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      // R3: ticks are isolated single-cycle strobes
      p_tick_gap_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/startup_stall_watch.sv
module startup_stall_watch #(
   parameter int unsigned LOCK_TICKS  = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic armed_i,
   input  logic tick_i,
   input  logic pulse_i,
   output logic stall_o
);

   localparam int unsigned CNT_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

   if (LOCK_TICKS == 0) begin : g_bad_lock
      $error("LOCK_TICKS must be at least 1");
   end

   logic pulse_s;

   if (SYNC_STAGES == 0) begin : g_no_sync
      assign pulse_s = pulse_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            sync_q <= '0;
         end else begin
            sync_q[0] <= pulse_i;
            for (int i = 1; i < int'(SYNC_STAGES); i++) sync_q[i] <= sync_q[i-1];
         end
      end
      assign pulse_s = sync_q[SYNC_STAGES-1];
   end

   logic             prev_q;
   logic             edge_seen;
   logic [CNT_W-1:0] quiet_q;

   assign edge_seen = pulse_s & ~prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         quiet_q <= '0;
      end else begin
         prev_q <= pulse_s;
         if (!armed_i || edge_seen)  quiet_q <= '0;
         else if (tick_i)            quiet_q <= (quiet_q == LAST) ? '0 : quiet_q + 1'b1;
      end
   end

   assign stall_o = armed_i & tick_i & ~edge_seen & (quiet_q == LAST);

   // R8: quiet-tick count stays inside the window
   p_quiet_bound_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      quiet_q <= LAST);
   // R8: an idle block carries no stale quiet count
   p_idle_clear_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_i |=> (quiet_q == '0));

endmodule

// File: rtl/startup_ramp_seq.sv
module startup_ramp_seq
   import startup_ramp_pkg::*;
#(
   parameter int unsigned TICK_CYCLES = 2_500_000,
   parameter int unsigned LOCK_TICKS  = 10,
   parameter int unsigned OFF_TICKS   = 50,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FREQ_W      = 17,
   parameter int unsigned ACC_W       = 9,
   parameter int unsigned AMP_W       = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [SET_CODE_W-1:0] code_i,
   input  logic                  vsel_i,
   input  logic                  start_i,
   input  logic                  lock_in_i,
   input  logic                  rot_pulse_i,
   output logic [FREQ_W-1:0]     freq_o,
   output logic [AMP_W-1:0]      amp_o,
   output logic                  drive_o,
   output logic                  open_loop_o,
   output logic                  off_o
);

   localparam int unsigned OFF_W = (OFF_TICKS > 1) ? $clog2(OFF_TICKS) : 1;
   localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_TICKS - 1);
   localparam int unsigned SUM_W = FREQ_W + 1;

   if (OFF_TICKS == 0) begin : g_bad_off
      $error("OFF_TICKS must be at least 1");
   end

   logic              cfg_valid;
   logic [ACC_W-1:0]  accel;
   logic [FREQ_W-1:0] ceil;
   logic              tick;
   logic              stall;
   logic              armed;

   seq_state_e        state_q;
   logic [FREQ_W-1:0] freq_q;
   logic [OFF_W-1:0]  off_cnt_q;
   logic [SUM_W-1:0]  step_sum;
   logic              at_ceiling;

   startup_cfg_latch #(
      .ACC_W  (ACC_W),
      .FREQ_W (FREQ_W),
      .AMP_W  (AMP_W)
   ) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .code_i  (code_i),
      .vsel_i  (vsel_i),
      .valid_o (cfg_valid),
      .accel_o (accel),
      .ceil_o  (ceil),
      .amp_o   (amp_o)
   );

   startup_tick_gen #(
      .TICK_CYCLES (TICK_CYCLES)
   ) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   assign armed = (state_q == SEQ_RAMP) || (state_q == SEQ_RUN);

   startup_stall_watch #(
      .LOCK_TICKS  (LOCK_TICKS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_stall (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .armed_i (armed),
      .tick_i  (tick),
      .pulse_i (rot_pulse_i),
      .stall_o (stall)
   );

   assign step_sum   = {1'b0, freq_q} + SUM_W'(accel);
   assign at_ceiling = step_sum >= {1'b0, ceil};

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !start_i) begin
         state_q   <= SEQ_IDLE;
         freq_q    <= '0;
         off_cnt_q <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (cfg_valid) begin
                  state_q <= SEQ_RAMP;
                  freq_q  <= '0;
               end
            end
            SEQ_RAMP: begin
               if (stall) begin
                  state_q   <= SEQ_OFF;
                  freq_q    <= '0;
                  off_cnt_q <= '0;
               end else if (lock_in_i) begin
                  state_q <= SEQ_RUN;
               end else if (tick) begin
                  if (at_ceiling) begin
                     freq_q  <= ceil;
                     state_q <= SEQ_RUN;
                  end else begin
                     freq_q <= step_sum[FREQ_W-1:0];
                  end
               end
            end
            SEQ_RUN: begin
               if (stall) begin
                  state_q   <= SEQ_OFF;
                  freq_q    <= '0;
                  off_cnt_q <= '0;
               end
            end
            SEQ_OFF: begin
               if (tick) begin
                  if (off_cnt_q == OFF_LAST) begin
                     state_q   <= SEQ_RAMP;
                     off_cnt_q <= '0;
                  end else begin
                     off_cnt_q <= off_cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign freq_o      = freq_q;
   assign drive_o     = armed;
   assign open_loop_o = (state_q == SEQ_RAMP);
   assign off_o       = (state_q == SEQ_OFF);

   // R5: the command never exceeds the latched ceiling
   p_freq_ceiling_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      freq_o <= ceil);
   // R3: the open-loop ramp only moves upward
   p_ramp_monotonic_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (open_loop_o && $past(open_loop_o)) |-> (freq_o >= $past(freq_o)));
   // R10: hand-over holds the frequency
   p_hold_after_handoff_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drive_o && !open_loop_o && $past(drive_o && !open_loop_o)) |-> $stable(freq_o));
   // R8: the off period carries no drive
   p_off_quiet_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_o |-> (!drive_o && !open_loop_o && freq_o == '0));
   // R6: lock-in during the ramp hands over with the frequency held
   p_lock_handoff_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (open_loop_o && lock_in_i && start_i && !stall) |=> (drive_o && !open_loop_o && $stable(freq_o)));
   // R9: off counter stays within the off window
   p_off_bound_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_cnt_q <= OFF_LAST);

endmodule

// File: tb/sim_startup_ramp_seq.sv
module sim_startup_ramp_seq;

   localparam int CLK_PERIOD = 10;
   localparam int TICK       = 8;
   localparam int LOCKT      = 4;
   localparam int OFFT       = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  code = 4'd0;
   logic        vsel = 1'b0;
   logic        start = 1'b0;
   logic        lock_in = 1'b0;
   logic        rot = 1'b0;
   logic [16:0] freq_o;
   logic [3:0]  amp_o;
   logic        drive_o, open_loop_o, off_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   startup_ramp_seq #(
      .TICK_CYCLES (TICK),
      .LOCK_TICKS  (LOCKT),
      .OFF_TICKS   (OFFT),
      .SYNC_STAGES (2)
   ) u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .code_i      (code),
      .vsel_i      (vsel),
      .start_i     (start),
      .lock_in_i   (lock_in),
      .rot_pulse_i (rot),
      .freq_o      (freq_o),
      .amp_o       (amp_o),
      .drive_o     (drive_o),
      .open_loop_o (open_loop_o),
      .off_o       (off_o)
   );

   typedef struct packed {
      logic [16:0] f;
      logic        d;
      logic        o;
      logic        x;
   } obs_t;

   obs_t  exp_q[$];
   string tag_q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    pulse_run = 1'b0;

   function automatic int exp_acc(input int c);
      case (c)
         0: return 31;   1: return 51;   2: return 70;   3: return 90;
         4: return 109;  5: return 148;  6: return 188;  default: return 266;
      endcase
   endfunction

   function automatic int exp_amp(input int c, input bit s);
      if (c > 7) return s ? 2 : 1;
      return s ? 6 : 3;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(input int f, input bit d, input bit o, input bit x, input string tag);
      obs_t it;
      it.f = 17'(f); it.d = d; it.o = o; it.x = x;
      exp_q.push_back(it);
      tag_q.push_back(tag);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // scoreboard monitor: every change of the output tuple consumes one expected item
   obs_t prev_obs = '0;
   always @(negedge clk) begin
      obs_t cur;
      cur = {freq_o, drive_o, open_loop_o, off_o};
      if (!rst_n) begin
         prev_obs = '0;
      end else if (cur != prev_obs) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 scoreboard unexpected change: actual %0d/%0b/%0b/%0b expected no change",
                     cur.f, cur.d, cur.o, cur.x);
         end else begin
            obs_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e != cur) begin
               n_fail++;
               $display("FAIL %s scoreboard: actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                        t, cur.f, cur.d, cur.o, cur.x, e.f, e.d, e.o, e.x);
            end
         end
         prev_obs = cur;
      end
   end

   // rotation pulses, one clock high every five clocks
   int pcnt = 0;
   always @(negedge clk) begin
      rot  = pulse_run && (pcnt == 0);
      pcnt = (pcnt == 4) ? 0 : pcnt + 1;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   task automatic drain(input int lim, input string tag);
      int n = 0;
      while (exp_q.size() != 0 && n < lim) begin
         @(negedge clk);
         n++;
      end
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL %s: actual %0d pending items expected 0", tag, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic do_reset(input int c, input bit s);
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0; lock_in = 1'b0; pulse_run = 1'b0;
      code = 4'(c); vsel = s;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 freq", freq_o, 0);
      chk("R1 amp", amp_o, 0);
      chk("R1 drive", drive_o, 0);
      chk("R1 open", open_loop_o, 0);
      chk("R1 off", off_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_freq(input int v, input int lim, input string tag);
      int n = 0;
      while (int'(freq_o) != v && n < lim) begin
         @(negedge clk);
         n++;
      end
      chk(tag, freq_o, v);
   endtask

   initial begin
      int n;
      // ---------- A: code 7, vsel 1, full slow ramp, stall and restart
      do_reset(7, 1'b1);
      code = 4'd0; vsel = 1'b0;          // R2: late change must be ignored
      repeat (2) @(negedge clk);
      chk("R2 R4 amp kept", amp_o, 6);
      push(0, 1, 1, 0, "R7 start");
      for (int k = 1; k * 266 < 50000; k++) push(k * 266, 1, 1, 0, "R2 R3 step");
      push(50000, 1, 0, 0, "R5 ceiling handoff");
      pulse_run = 1'b1;
      start = 1'b1;
      wait_freq(266, 100, "R3 first step");
      n = 0;
      while (int'(freq_o) == 266 && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R3 tick spacing", n, TICK);
      drain(4000, "R5 ramp");
      repeat (20) @(negedge clk);
      chk("R10 hold", freq_o, 50000);
      chk("R10 drive", drive_o, 1);
      push(0, 0, 0, 1, "R8 stall");
      pulse_run = 1'b0;
      n = 0;
      while (!off_o && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R8 stall seen", off_o, 1);
      chk("R8 latency ok", (n >= (LOCKT - 1) * TICK - 5 && n <= LOCKT * TICK + 5), 1);
      push(0, 1, 1, 0, "R9 restart");
      push(266, 1, 1, 0, "R9 step");
      push(532, 1, 1, 0, "R9 step");
      pulse_run = 1'b1;
      n = 0;
      while (off_o && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R9 off length", n, OFFT * TICK);
      drain(100, "R9 restart");
      push(0, 0, 0, 0, "R7 stop");
      start = 1'b0;
      drain(10, "R7 stop");
      pulse_run = 1'b0;
      repeat (60) @(negedge clk);
      chk("R8 no stall idle", off_o, 0);

      // ---------- B: code 12 (fast alias), vsel 0, lock-in hand-over
      do_reset(12, 1'b0);
      chk("R4 amp fast low", amp_o, 1);
      push(0, 1, 1, 0, "R7 start");
      push(266, 1, 1, 0, "R3 step");
      push(532, 1, 1, 0, "R3 step");
      push(798, 1, 1, 0, "R3 step");
      pulse_run = 1'b1;
      start = 1'b1;
      wait_freq(798, 200, "R3 reach");
      push(798, 1, 0, 0, "R6 lock-in");
      lock_in = 1'b1;
      @(negedge clk);
      lock_in = 1'b0;
      drain(10, "R6 lock-in");
      repeat (30) @(negedge clk);
      chk("R10 hold lock", freq_o, 798);
      push(0, 0, 0, 0, "R7 stop");
      start = 1'b0;
      drain(10, "R7 stop");

      // ---------- C: code 8, vsel 1, full fast ramp
      do_reset(8, 1'b1);
      chk("R4 amp fast high", amp_o, 2);
      push(0, 1, 1, 0, "R7 start");
      for (int k = 1; k * 266 < 100000; k++) push(k * 266, 1, 1, 0, "R3 step");
      push(100000, 1, 0, 0, "R5 fast ceiling");
      pulse_run = 1'b1;
      start = 1'b1;
      drain(5000, "R5 fast ramp");
      push(0, 0, 0, 0, "R7 stop");
      start = 1'b0;
      drain(10, "R7 stop");

      // ---------- D: code sweep
      for (int c = 0; c <= 8; c++) begin
         int cc;
         bit s;
         cc = (c == 8) ? 15 : c;
         s  = c[0];
         do_reset(cc, s);
         chk("R4 amp sweep", amp_o, exp_amp(cc, s));
         push(0, 1, 1, 0, "R7 start");
         push(exp_acc(cc), 1, 1, 0, "R3 sweep step");
         push(2 * exp_acc(cc), 1, 1, 0, "R3 sweep step");
         pulse_run = 1'b1;
         start = 1'b1;
         drain(100, "R3 sweep");
         push(0, 0, 0, 0, "R7 stop");
         start = 1'b0;
         drain(10, "R7 stop");
      end

      repeat (5) @(negedge clk);
      finish_up();
   end

endmodule